// File: doc/BRIEF.md
# Rectangular Block Transfer Bus Sequencer

This block generates the memory bus traffic for moving a rectangle of pixel data between two regions of memory. The combining of source and destination data is done by a separate raster-operation unit that watches the same bus. The sequencer only decides which cycle comes next and at which address. Software supplies two base addresses, a line width in bytes, a line count, a signed per-word step, two per-line warp offsets and a flag that skips the pipeline-priming read. Then it pulses `start`.

For each word the sequencer issues a source read, a destination read and a destination write, all through one request/ready memory port. Unless the flag suppresses it, an extra source read at the head of every line fills the external unit's pipeline register. At each line end both pointers are adjusted by their warps. When the last line is finished, `done` pulses and the pointer outputs hold the final adjusted addresses.

Top module: `blit_bus_seq`

## Requirements
- R1: Each word is moved as exactly three bus cycles in the fixed order source read (`mem_we`=0 at the source pointer), destination read (`mem_we`=0 at the destination pointer), destination write (`mem_we`=1 at the destination pointer).
- R2: A line holds ceil(`width`/2) words, counted by a width counter reloaded at every line start and lowered by 2 per word. The transfer covers exactly `height` lines.
- R3: After each word, both pointers move by the signed `step` (two's complement, `ADDR_W` bits). A positive step walks addresses upward and a negative step walks them downward.
- R4: With `no_prime`=0, one extra source read at the current source pointer opens every line, and the source pointer then moves by `step`. With `no_prime`=1 no such read is issued. The flag is captured at `start`.
- R5: At each line end, `src_warp` is added to the source pointer and `dst_warp` to the destination pointer, in a cycle with no bus request.
- R6: When `done` is high, `src_ptr` and `dst_ptr` hold the pointers after the final word steps and final warps. `step`, `src_warp` and `dst_warp` must be held stable by the user during a transfer.
- R7: A `start` with `width`=0 or `height`=0 issues no bus cycle and raises `done` in the cycle after the start edge.
- R8: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we` and `mem_addr` hold their values. The sequence advances only on a cycle with `mem_ready` high.
- R9: `done` is a single-cycle pulse with no request in that cycle. A `start` received while a transfer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| src_base | input | ADDR_W | Source start address |
| dst_base | input | ADDR_W | Destination start address |
| width | input | CNT_W | Line width in bytes |
| height | input | CNT_W | Number of lines |
| step | input | ADDR_W | Signed per-word pointer step |
| src_warp | input | ADDR_W | Signed source line-end adjustment |
| dst_warp | input | ADDR_W | Signed destination line-end adjustment |
| no_prime | input | 1 | 1 skips the per-line priming source read |
| mem_req | output | 1 | Bus cycle request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Bus cycle address |
| mem_ready | input | 1 | Current bus cycle completes this clock |
| done | output | 1 | One-cycle completion pulse |
| src_ptr | output | ADDR_W | Current / final source pointer |
| dst_ptr | output | ADDR_W | Current / final destination pointer |

## Verification
The hardest situation to reach is a wait-stated bus cycle that lands on the last word of a line. There, address hold, the width-counter end test and the warp step all meet. The bench reaches it by driving `mem_ready` low on alternate cycles while transferring odd and even widths with both step signs. It also reaches a mid-transfer `start` by raising `start` again, with different bases and sizes, a few cycles after the transfer is accepted. The bench then compares the full logged bus trace and the final pointers with a model built from the requirements.

// File: rtl/blit_pkg.sv
package blit_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRIME,
      ST_SRD,
      ST_DRD,
      ST_DWR,
      ST_LEND,
      ST_FIN
   } seq_state_t;
endpackage

// File: rtl/blit_ptr_reg.sv
module blit_ptr_reg #(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              step_en,
   input  logic [ADDR_W-1:0] step,
   input  logic              warp_en,
   input  logic [ADDR_W-1:0] warp,
   output logic [ADDR_W-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr <= '0;
      else if (load)    ptr <= base;
      else if (step_en) ptr <= ptr + step;
      else if (warp_en) ptr <= ptr + warp;
   end
endmodule

// File: rtl/blit_span_ctr.sv
module blit_span_ctr #(
   parameter int CNT_W      = 16,
   parameter int WORD_BYTES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] width,
   input  logic [CNT_W-1:0] height,
   input  logic             word_adv,
   input  logic             line_end,
   output logic             last_word,
   output logic             last_line
);
   localparam logic [CNT_W-1:0] WB_C = CNT_W'(WORD_BYTES);

   logic [CNT_W-1:0] width_q;
   logic [CNT_W-1:0] cur_w;
   logic [CNT_W-1:0] lines_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width_q    <= '0;
         cur_w      <= '0;
         lines_left <= '0;
      end else if (load) begin
         width_q    <= width;
         cur_w      <= width;
         lines_left <= height;
      end else if (line_end) begin
         cur_w      <= width_q;
         lines_left <= lines_left - 1'b1;
      end else if (word_adv && !last_word) begin
         cur_w <= cur_w - WB_C;
      end
   end

   assign last_word = (cur_w <= WB_C);
   assign last_line = (lines_left == CNT_W'(1));
endmodule

// File: rtl/blit_seq_fsm.sv
module blit_seq_fsm
   import blit_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       zero_size,
   input  logic       no_prime,
   input  logic       mem_ready,
   input  logic       last_word,
   input  logic       last_line,
   output seq_state_t state,
   output logic       load,
   output logic       prime_adv,
   output logic       word_adv,
   output logic       line_end,
   output logic       busy,
   output logic       done
);
   seq_state_t nxt;
   logic       skip_prime;
   seq_state_t line_head;

   assign load      = (state == ST_IDLE) && start && !zero_size;
   assign prime_adv = (state == ST_PRIME) && mem_ready;
   assign word_adv  = (state == ST_DWR) && mem_ready;
   assign line_end  = (state == ST_LEND);
   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_FIN);
   assign line_head = skip_prime ? ST_SRD : ST_PRIME;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    skip_prime <= 1'b0;
      else if (load) skip_prime <= no_prime;
   end

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (start) nxt = zero_size ? ST_FIN : (no_prime ? ST_SRD : ST_PRIME);
         ST_PRIME: if (mem_ready) nxt = ST_SRD;
         ST_SRD:   if (mem_ready) nxt = ST_DRD;
         ST_DRD:   if (mem_ready) nxt = ST_DWR;
         ST_DWR:   if (mem_ready) nxt = last_word ? ST_LEND : ST_SRD;
         ST_LEND:  nxt = last_line ? ST_FIN : line_head;
         ST_FIN:   nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/blit_bus_seq.sv
module blit_bus_seq
   import blit_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int CNT_W      = 16,
   parameter int WORD_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] src_base,
   input  logic [ADDR_W-1:0] dst_base,
   input  logic [CNT_W-1:0]  width,
   input  logic [CNT_W-1:0]  height,
   input  logic [ADDR_W-1:0] step,
   input  logic [ADDR_W-1:0] src_warp,
   input  logic [ADDR_W-1:0] dst_warp,
   input  logic              no_prime,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ready,
   output logic              done,
   output logic [ADDR_W-1:0] src_ptr,
   output logic [ADDR_W-1:0] dst_ptr
);
   localparam int N_PTR = 2;

   if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_wb
      $error("WORD_BYTES must be a power of two");
   end
   if (CNT_W < 2 || ADDR_W < 4) begin : g_bad_w
      $error("CNT_W or ADDR_W too small");
   end

   seq_state_t  state;
   logic        load, prime_adv, word_adv, line_end, busy;
   logic        last_word, last_line;
   logic        zero_size;

   logic [ADDR_W-1:0] p_base [N_PTR];
   logic [ADDR_W-1:0] p_warp [N_PTR];
   logic [ADDR_W-1:0] p_val  [N_PTR];
   logic              p_step [N_PTR];

   assign zero_size = (width == '0) || (height == '0);

   assign p_base[0] = src_base;
   assign p_base[1] = dst_base;
   assign p_warp[0] = src_warp;
   assign p_warp[1] = dst_warp;
   assign p_step[0] = word_adv || prime_adv;
   assign p_step[1] = word_adv;

   blit_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .zero_size(zero_size),
      .no_prime(no_prime), .mem_ready(mem_ready), .last_word(last_word),
      .last_line(last_line), .state(state), .load(load),
      .prime_adv(prime_adv), .word_adv(word_adv), .line_end(line_end),
      .busy(busy), .done(done)
   );

   blit_span_ctr #(.CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_span (
      .clk(clk), .rst_n(rst_n), .load(load), .width(width), .height(height),
      .word_adv(word_adv), .line_end(line_end),
      .last_word(last_word), .last_line(last_line)
   );

   for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
      blit_ptr_reg #(.ADDR_W(ADDR_W)) u_ptr (
         .clk(clk), .rst_n(rst_n), .load(load), .base(p_base[g]),
         .step_en(p_step[g]), .step(step), .warp_en(line_end),
         .warp(p_warp[g]), .ptr(p_val[g])
      );
   end

   assign src_ptr  = p_val[0];
   assign dst_ptr  = p_val[1];
   assign mem_req  = (state == ST_PRIME) || (state == ST_SRD) ||
                     (state == ST_DRD)   || (state == ST_DWR);
   assign mem_we   = (state == ST_DWR);
   assign mem_addr = ((state == ST_DRD) || (state == ST_DWR)) ? dst_ptr : src_ptr;
endmodule

// File: rtl/blit_bus_seq_chk.sv
module blit_bus_seq_chk #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              zero_size,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              done,
   input logic [ADDR_W-1:0] dst_ptr,
   input logic [ADDR_W-1:0] step
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R8
   AST_WRITE_ENDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_ready |=> !mem_we); // R1
   AST_DST_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_ready |=> dst_ptr == $past(dst_ptr) + $past(step)); // R3
   AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start && zero_size |=> done && !mem_req); // R7
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
endmodule

bind blit_bus_seq blit_bus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
   .zero_size(zero_size), .mem_req(mem_req), .mem_we(mem_we),
   .mem_ready(mem_ready), .mem_addr(mem_addr), .done(done),
   .dst_ptr(dst_ptr), .step(step)
);

// File: tb/blit_bus_seq_bench.sv
module blit_bus_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 24;
   localparam int CW = 16;
   localparam int LOG_MAX = 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] src_base = '0, dst_base = '0, step = '0, src_warp = '0, dst_warp = '0;
   logic [CW-1:0] width = '0, height = '0;
   logic          no_prime = 1'b0;
   logic          mem_req, mem_we, done;
   logic [AW-1:0] mem_addr, src_ptr, dst_ptr;
   logic          mem_ready;
   logic          stall_mode = 1'b0;
   logic [7:0]    cyc = '0;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   logic [1:0]    log_kind [LOG_MAX];
   logic [AW-1:0] log_addr [LOG_MAX];
   int            log_n = 0;
   logic [1:0]    exp_kind [LOG_MAX];
   logic [AW-1:0] exp_addr [LOG_MAX];
   int            exp_n;

   blit_bus_seq u_blit_bus_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base),
      .dst_base(dst_base), .width(width), .height(height), .step(step),
      .src_warp(src_warp), .dst_warp(dst_warp), .no_prime(no_prime),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_ready(mem_ready), .done(done), .src_ptr(src_ptr), .dst_ptr(dst_ptr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 8'd1;
   assign mem_ready = stall_mode ? cyc[0] : 1'b1;

   // Bus monitor: kind 0 = source read, 1 = destination read, 2 = write
   always @(negedge clk) begin
      if (rst_n && mem_req && mem_ready && log_n < LOG_MAX) begin
         log_kind[log_n] <= mem_we ? 2'd2 : ((mem_addr == dst_ptr && mem_addr != src_ptr) ? 2'd1 : 2'd0);
         log_addr[log_n] <= mem_addr;
         log_n <= log_n + 1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [1:0] k, input logic [AW-1:0] a);
      exp_kind[exp_n] = k;
      exp_addr[exp_n] = a;
      exp_n++;
   endtask

   task automatic run_blit(input logic [AW-1:0] sb, input logic [AW-1:0] db,
                           input logic [CW-1:0] w, input logic [CW-1:0] h,
                           input logic [AW-1:0] st, input logic [AW-1:0] sw,
                           input logic [AW-1:0] dw, input logic np,
                           input logic stall, input bit restart);
      int first;
      int words;
      logic [AW-1:0] sp, dp;
      bit seen;
      seen = 0;
      @(negedge clk);
      stall_mode = stall;
      first = log_n;
      src_base = sb; dst_base = db; width = w; height = h;
      step = st; src_warp = sw; dst_warp = dw; no_prime = np;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 4000 && !seen; i++) begin
         if (restart && i == 3) begin
            start = 1'b1; src_base = sb + 24'h100; dst_base = db + 24'h100;
            width = w + 16'd4; height = h + 16'd1;
         end else if (restart && i == 4) begin
            start = 1'b0;
         end
         if (done) seen = 1;
         else @(negedge clk);
      end
      check(seen, "R2", "done reached", seen, 1);
      // expected trace from the requirements
      exp_n = 0; sp = sb; dp = db;
      words = (int'(w) + 1) / 2;
      for (int l = 0; l < int'(h); l++) begin
         if (!np) begin push(2'd0, sp); sp = sp + st; end // R4
         for (int k = 0; k < words; k++) begin
            push(2'd0, sp); push(2'd1, dp); push(2'd2, dp); // R1
            sp = sp + st; dp = dp + st;                     // R3
         end
         sp = sp + sw; dp = dp + dw;                        // R5
      end
      check((log_n - first) == exp_n, "R2", "bus cycle count", log_n - first, exp_n);
      for (int j = 0; j < exp_n && j < log_n - first; j++) begin
         check(log_addr[first+j] == exp_addr[j], "R3", "bus address", log_addr[first+j], exp_addr[j]);
         check(log_kind[first+j] == exp_kind[j], "R1", "bus cycle kind", log_kind[first+j], exp_kind[j]);
      end
      check(src_ptr == sp, "R6", "final source pointer", src_ptr, sp);
      check(dst_ptr == dp, "R6", "final destination pointer", dst_ptr, dp);
      check(!mem_req, "R9", "no request with done", mem_req, 0);
      @(negedge clk);
      check(!done, "R9", "done is one pulse", done, 0);
      if (restart) begin
         @(negedge clk);
         check(!mem_req && src_ptr == sp, "R9", "start while busy ignored", src_ptr, sp);
      end
   endtask

   task automatic run_zero(input logic [CW-1:0] w, input logic [CW-1:0] h);
      int first;
      @(negedge clk);
      stall_mode = 1'b0;
      first = log_n;
      width = w; height = h; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done, "R7", "done one cycle after zero-size start", done, 1);
      @(negedge clk);
      check(log_n == first, "R7", "no bus cycle on zero size", log_n - first, 0);
      check(!done, "R9", "zero-size done is one pulse", done, 0);
   endtask

   task automatic check_reset();
      @(negedge clk);
      check(!mem_req && !done, "R9", "idle after reset", {mem_req, done}, 0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_reset();
      // R1 R2 R4 R5: upward, priming, no stalls
      run_blit(24'h001000, 24'h008000, 16'd6, 16'd2, 24'h000002, 24'h000100, 24'h000200, 1'b0, 1'b0, 0);
      // R3 R4 R8: downward, no priming, wait states
      run_blit(24'h004000, 24'h00A000, 16'd4, 16'd3, 24'hFFFFFE, 24'hFFFF00, 24'hFFFE80, 1'b1, 1'b1, 0);
      // R2 R8: odd width, priming, wait states
      run_blit(24'h000200, 24'h000800, 16'd5, 16'd1, 24'h000002, 24'h000010, 24'h000020, 1'b0, 1'b1, 0);
      // R7: zero width, then zero height
      run_zero(16'd0, 16'd3);
      run_zero(16'd8, 16'd0);
      // R9: second start during a running transfer
      run_blit(24'h002000, 24'h003000, 16'd8, 16'd2, 24'h000002, 24'h000040, 24'h000080, 1'b0, 1'b1, 1);
      finish_run();
   end
endmodule